// File: doc/BRIEF.md
# Data-Stationary Pipeline Control Chain

This block decodes each instruction once, in the decode stage, into a complete control word. It then carries that word down a five-stage in-order pipeline with the instruction, so each stage finds its own controls in its own pipeline register. The execute stage receives operand-extension, ALU-source, ALU-operation and destination-select fields. The memory stage receives memory-write and branch. The writeback stage receives result-select and register-write.

The fetch stage is outside the block. It presents the opcode and function fields of each fetched instruction together with a valid flag. The block holds them in its fetch/decode register, decodes them, and moves the control word through the execute, memory and writeback registers. Each register has a valid bit.

- A stall holds the fetch/decode register and sends a bubble into execute.
- A flush invalidates the instruction being loaded into fetch/decode, which squashes the instruction in a branch shadow.

Every instruction that writes a register does so from stage 5, so the single write-port enable is produced in one place only. Memory-write, branch and register-write enables are gated with the valid bit of their stage.

Top module: `pipe_ctl_chain`

## Requirements
- R1: After reset, `ex_valid`, `mem_valid`, `wb_valid`, `mem_write`, `mem_branch` and `rf_we` are all 0.
- R2: An instruction accepted at a clock edge (`fetch_valid`=1, no stall) has its decoded execute controls on the outputs after the next edge, with `ex_valid`=1. Control word {ext_sign, alu_imm, alu_op[1:0], dst_rd, mem_write, branch, from_mem, reg_write} is decoded as follows:
  - opcode 0x00 with function 0x20/0x22/0x24/0x25 gives ALU op 0/1/2/3, with dst_rd=1 and reg_write=1.
  - 0x23 (load) gives ext_sign=1, alu_imm=1, from_mem=1, reg_write=1.
  - 0x2B (store) gives ext_sign=1, alu_imm=1, mem_write=1.
  - 0x04 (branch-equal) gives ext_sign=1, alu_op=1, branch=1.
  - 0x08 (add-immediate) gives ext_sign=1, alu_imm=1, reg_write=1.
  - 0x0D (or-immediate) gives alu_imm=1, alu_op=3, reg_write=1.
  - All other fields are 0.
- R3: `mem_write` and `mem_branch` reflect the instruction one cycle after it was in execute.
- R4: `rf_we` and `wb_from_mem` reflect the instruction one cycle after the memory stage, three cycles after decode, for register-type and load instructions alike; `rf_we` is never raised earlier.
- R5: While `stall` is 1, the fetch/decode register keeps its instruction and ignores the fetch inputs, execute receives a bubble (`ex_valid`=0, all execute controls 0), and the memory and writeback stages keep advancing.
- R6: `flush` at an edge loads the fetch/decode register as invalid. That instruction still carries decoded controls down the pipe, but its `mem_write`, `mem_branch` and `rf_we` stay 0.
- R7: With `stall` and `flush` together, the held instruction is invalidated and execute gets a bubble. The instruction does not reappear as valid when the stall ends.
- R8: Any opcode, or register-type function code, not listed in R2 decodes to an all-zero control word.
- R9: An edge with `fetch_valid`=0 and no stall loads an invalid instruction into fetch/decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetched instruction present |
| fetch_op | input | 6 | Opcode field of fetched instruction |
| fetch_fn | input | 6 | Function field of fetched instruction |
| stall | input | 1 | Hold decode, bubble into execute |
| flush | input | 1 | Invalidate instruction entering decode |
| ex_valid | output | 1 | Execute stage holds a live instruction |
| ex_ext_sign | output | 1 | Sign-extend immediate (else zero-extend) |
| ex_alu_imm | output | 1 | ALU second operand is the immediate |
| ex_alu_op | output | 2 | 0 add, 1 subtract, 2 and, 3 or |
| ex_dst_rd | output | 1 | Destination is rd field (else rt) |
| mem_valid | output | 1 | Memory stage holds a live instruction |
| mem_write | output | 1 | Data memory write, valid-gated |
| mem_branch | output | 1 | Branch instruction, valid-gated |
| wb_valid | output | 1 | Writeback stage holds a live instruction |
| wb_from_mem | output | 1 | Write-back value comes from memory |
| rf_we | output | 1 | Register-file write enable, valid-gated |

## Verification
Stall and flush can be asserted in the same cycle. The bench raises both while an add-immediate sits in decode and then drops them. It then requires that execute saw a bubble, that the held instruction re-enters execute only as invalid, and that no register write appears three cycles later. A flush is also raised while an earlier store and branch are still in flight. This shows that squashing the shadow instruction leaves the delay-slot store's memory write intact.

// File: rtl/pipe_ctl_chain.sv
module pipe_ctl_chain (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_valid,
  input  logic [5:0] fetch_op,
  input  logic [5:0] fetch_fn,
  input  logic       stall,
  input  logic       flush,
  output logic       ex_valid,
  output logic       ex_ext_sign,
  output logic       ex_alu_imm,
  output logic [1:0] ex_alu_op,
  output logic       ex_dst_rd,
  output logic       mem_valid,
  output logic       mem_write,
  output logic       mem_branch,
  output logic       wb_valid,
  output logic       wb_from_mem,
  output logic       rf_we
);
  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_LOAD = 6'h23;
  localparam logic [5:0] OP_STOR = 6'h2B;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;

  logic       id_v, ex_v, mem_v, wb_v;
  logic [5:0] id_op, id_fn;
  logic [8:0] dec, ex_c;
  logic [3:0] mem_c;
  logic [1:0] wb_c;

  // word: ext, imm, op[1:0], dst | mem_wr, branch | from_mem, reg_wr
  always_comb begin
    dec = '0;
    case (id_op)
      OP_REG: case (id_fn)
        FN_ADD: dec = 9'b0_0_00_1_00_01;
        FN_SUB: dec = 9'b0_0_01_1_00_01;
        FN_AND: dec = 9'b0_0_10_1_00_01;
        FN_OR:  dec = 9'b0_0_11_1_00_01;
        default: dec = '0;
      endcase
      OP_LOAD: dec = 9'b1_1_00_0_00_11;
      OP_STOR: dec = 9'b1_1_00_0_10_00;
      OP_BEQ:  dec = 9'b1_0_01_0_01_00;
      OP_ADDI: dec = 9'b1_1_00_0_00_01;
      OP_ORI:  dec = 9'b0_1_11_0_00_01;
      default: dec = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_v <= 1'b0; id_op <= '0; id_fn <= '0;
      ex_v <= 1'b0; ex_c <= '0;
      mem_v <= 1'b0; mem_c <= '0;
      wb_v <= 1'b0; wb_c <= '0;
    end else begin
      if (!stall) begin
        id_op <= fetch_op;
        id_fn <= fetch_fn;
      end
      id_v <= flush ? 1'b0 : (stall ? id_v : fetch_valid);
      ex_v <= stall ? 1'b0 : id_v;
      ex_c <= stall ? '0 : dec;
      mem_v <= ex_v;
      mem_c <= ex_c[3:0];
      wb_v <= mem_v;
      wb_c <= mem_c[1:0];
    end
  end

  assign ex_valid    = ex_v;
  assign ex_ext_sign = ex_c[8];
  assign ex_alu_imm  = ex_c[7];
  assign ex_alu_op   = ex_c[6:5];
  assign ex_dst_rd   = ex_c[4];
  assign mem_valid   = mem_v;
  assign mem_write   = mem_v & mem_c[3];
  assign mem_branch  = mem_v & mem_c[2];
  assign wb_valid    = wb_v;
  assign wb_from_mem = wb_c[1];
  assign rf_we       = wb_v & wb_c[0];

  // R5
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_valid);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !flush) |=> (id_v == $past(id_v)) && $stable(id_op) && $stable(id_fn));
  // R6
  flush_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !id_v);
  // R3
  mem_write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_write |-> $past(ex_v && ex_c[3]));
  // R4
  rf_we_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(mem_v && mem_c[0]));
  // R9
  fetch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !stall) |=> !id_v);
endmodule

// File: tb/sim_pipe_ctl_chain.sv
module sim_pipe_ctl_chain;
  localparam int HALF = 5;
  localparam int LIMIT = 200000;

  logic clk = 0, rst_n = 0;
  logic fetch_valid = 0, stall = 0, flush = 0;
  logic [5:0] fetch_op = 0, fetch_fn = 0;
  logic ex_valid, ex_ext_sign, ex_alu_imm, ex_dst_rd;
  logic [1:0] ex_alu_op;
  logic mem_valid, mem_write, mem_branch, wb_valid, wb_from_mem, rf_we;
  int checks = 0, errors = 0;
  bit done = 0;

  always #HALF clk = ~clk;

  pipe_ctl_chain u0 (.*);

  // expected word {ext, imm, op[1:0], dst, mem_wr, branch, from_mem, reg_wr} per R2/R8
  function automatic logic [8:0] expw(input logic [5:0] op, input logic [5:0] fn);
    logic [8:0] w = '0;
    if (op == 6'h00) begin
      if (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25) begin
        w[6:5] = fn[2] ? {1'b1, fn[0]} : {1'b0, fn[1]};
        w[4] = 1'b1; w[0] = 1'b1;
      end
    end else if (op == 6'h23) w = {1'b1,1'b1,2'd0,1'b0,2'b00,2'b11};
    else if (op == 6'h2B) w = {1'b1,1'b1,2'd0,1'b0,2'b10,2'b00};
    else if (op == 6'h04) w = {1'b1,1'b0,2'd1,1'b0,2'b01,2'b00};
    else if (op == 6'h08) w = {1'b1,1'b1,2'd0,1'b0,2'b00,2'b01};
    else if (op == 6'h0D) w = {1'b0,1'b1,2'd3,1'b0,2'b00,2'b01};
    return w;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exf();
    return {ex_ext_sign, ex_alu_imm, ex_alu_op, ex_dst_rd};
  endfunction

  task automatic run_one(input logic [5:0] op, input logic [5:0] fn);
    logic [8:0] w = expw(op, fn);
    @(negedge clk); fetch_op = op; fetch_fn = fn; fetch_valid = 1;
    @(negedge clk); fetch_valid = 0;
    @(negedge clk);
    chk("R2/R8 ex ctl", {10'd0, ex_valid, exf()}, {10'd0, 1'b1, w[8:4]});
    @(negedge clk);
    chk("R3 mem ctl", {13'd0, mem_valid, mem_write, mem_branch}, {13'd0, 1'b1, w[3], w[2]});
    chk("R4 no early rf_we", {15'd0, rf_we}, 16'd0);
    @(negedge clk);
    chk("R4 wb ctl", {13'd0, wb_valid, wb_from_mem, rf_we}, {13'd0, 1'b1, w[1], w[0]});
    @(negedge clk);
    chk("R9 drained", {13'd0, ex_valid, mem_valid, wb_valid}, 16'd0);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1
    chk("R1 reset", {10'd0, ex_valid, mem_valid, wb_valid, mem_write, mem_branch, rf_we}, 16'd0);

    for (int op = 0; op < 64; op++) run_one(6'(op), 6'h20);
    for (int fn = 0; fn < 64; fn++) run_one(6'h00, 6'(fn));

    // R5 stall: ori ahead keeps moving, store held, add blocked
    @(negedge clk); fetch_op = 6'h0D; fetch_fn = 0; fetch_valid = 1;
    @(negedge clk); fetch_op = 6'h2B;
    @(negedge clk); stall = 1; fetch_op = 6'h00; fetch_fn = 6'h20;
    @(negedge clk);
    chk("R5 bubble", {10'd0, ex_valid, exf()}, 16'd0);
    @(negedge clk);
    chk("R5 bubble 2", {10'd0, ex_valid, exf()}, 16'd0);
    chk("R5 later stage advances", {15'd0, rf_we}, 16'd1);
    stall = 0;
    @(negedge clk); fetch_valid = 0;
    chk("R5 held store", {10'd0, ex_valid, exf()}, {10'd0, 1'b1, expw(6'h2B, 0)[8:4]});
    @(negedge clk);
    chk("R5 store write", {15'd0, mem_write}, 16'd1);
    chk("R5 add after stall", {10'd0, ex_valid, exf()}, {10'd0, 1'b1, expw(6'h00, 6'h20)[8:4]});
    @(negedge clk);
    chk("R5 store no rf_we", {15'd0, rf_we}, 16'd0);
    @(negedge clk);
    chk("R5 add writes", {15'd0, rf_we}, 16'd1);
    repeat (3) @(negedge clk);

    // R6 flush: branch, delay-slot store kept, addi squashed
    fetch_op = 6'h04; fetch_valid = 1;
    @(negedge clk); fetch_op = 6'h2B;
    @(negedge clk); fetch_op = 6'h08; flush = 1;
    @(negedge clk); flush = 0; fetch_valid = 0;
    chk("R6 branch in mem", {15'd0, mem_branch}, 16'd1);
    chk("R6 slot in ex", {15'd0, ex_valid}, 16'd1);
    @(negedge clk);
    chk("R6 squashed ex", {10'd0, ex_valid, exf()}, {10'd0, 1'b0, expw(6'h08, 0)[8:4]});
    chk("R6 slot store writes", {15'd0, mem_write}, 16'd1);
    @(negedge clk);
    chk("R6 squashed mem", {14'd0, mem_valid, mem_write}, 16'd0);
    @(negedge clk);
    chk("R6 squashed no rf_we", {14'd0, wb_valid, rf_we}, 16'd0);
    repeat (2) @(negedge clk);

    // R7 stall and flush together
    fetch_op = 6'h08; fetch_valid = 1;
    @(negedge clk); stall = 1; flush = 1; fetch_op = 6'h23;
    @(negedge clk); stall = 0; flush = 0; fetch_valid = 0;
    chk("R7 bubble", {10'd0, ex_valid, exf()}, 16'd0);
    @(negedge clk);
    chk("R7 held is invalid", {15'd0, ex_valid}, 16'd0);
    @(negedge clk);
    chk("R7 no mem", {15'd0, mem_valid}, 16'd0);
    @(negedge clk);
    chk("R7 no rf_we", {14'd0, wb_valid, rf_we}, 16'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule